// File: doc/BRIEF.md
# Two-wire serial memory slave front end

This block is the bus-facing part of a two-wire serial memory. It runs entirely in the system clock domain. The raw clock and data lines are oversampled through a synchroniser, and bus edges and the START and STOP conditions are found by comparing successive samples. A state machine shifts in 8-bit words with the most significant bit first and checks the first word after START as a device-select word. It acknowledges each accepted word by pulling the data line low for the ninth clock. The data line is modelled as an open-drain output enable: when `sda_oe_o` is high, the line is pulled low.

In a write transfer, the block hands the word address and then each data byte to the write block as one-cycle strobes. At a closing STOP, it signals that programming may begin. In a read transfer, it asks the read block for a byte and captures it. It shifts the byte out on the falling edges of the bus clock. It keeps going while the master acknowledges and stops when the master does not. While the write block reports that programming is busy, a device-select word is not acknowledged, so the master can poll for completion. A parameter chooses whether the three select bits are compared against the select pins or ignored.

The states are named as follows:
- `ST_IDLE`: standby after reset or STOP.
- `ST_SEL`: receiving the select word.
- `ST_SEL_ACK`: acknowledging the select word.
- `ST_ADDR` and `ST_ADDR_ACK`: receiving and acknowledging the word address.
- `ST_WDAT` and `ST_WDAT_ACK`: receiving and acknowledging data.
- `ST_RDAT`: shifting a byte out.
- `ST_RD_MACK`: the master's acknowledge bit.
- `ST_HOLD`: ignoring the bus until the next START or STOP.

The transitions are as follows:
- START in any state goes to `ST_SEL`. STOP in any state goes to `ST_IDLE`.
- `ST_SEL` goes to `ST_SEL_ACK` on an accepted select word and to `ST_HOLD` otherwise.
- `ST_SEL_ACK` goes to `ST_ADDR` for a write or to `ST_RDAT` for a read.
- `ST_ADDR_ACK` goes to `ST_WDAT`.
- `ST_WDAT_ACK` goes back to `ST_WDAT`.
- `ST_RDAT` goes to `ST_RD_MACK`.
- `ST_RD_MACK` goes to `ST_RDAT` if the master acknowledged, or to `ST_HOLD` if it did not.

Top module: `twi_mem_front`

## Requirements
- R1: After reset, `sda_oe_o` is low and none of the strobes `addr_we_o`, `data_we_o`, `rd_load_o` or `wr_end_o` is asserted.
- R2: A STOP (data rising while the clock is high) returns the block to standby. Words clocked in afterwards without a new START are never acknowledged.
- R3: The select word's bits 7..4 must be 1010. Bit 0 is the direction: 1 means read, 0 means write. A word with any other prefix is not acknowledged, and the rest of the transfer is ignored.
- R4: With select matching enabled, bits 3..1 of the select word must equal `sel_pins_i[2:0]`. On a mismatch there is no acknowledge, and the line stays released until the next START.
- R5: An accepted word is acknowledged by driving `sda_oe_o` high from the eighth falling clock edge until the ninth falling clock edge. `sda_oe_o` only ever changes while the bus clock is low.
- R6: If `busy_i` is high when the select word completes, the word is not acknowledged. The same word is acknowledged once `busy_i` is low.
- R7: In a write, the byte after the select word is presented on `byte_o` with a one-cycle `addr_we_o` strobe. Each following byte is presented with a one-cycle `data_we_o` strobe. Every one of these bytes is acknowledged.
- R8: In a read, at the ninth falling edge of the select word, `rd_load_o` pulses and `rd_data_i` is captured. The byte is driven MSB first, with `sda_oe_o` equal to the inverse of each bit, and each bit changes after a falling clock edge. The line is released for the master's acknowledge bit.
- R9: If the master acknowledges (data low on the ninth clock of a read byte), the next byte is loaded with `rd_load_o` and sent. If the master does not acknowledge, the line stays released until the next START or STOP.
- R10: `wr_end_o` pulses once for a STOP that ends a write in which at least one data byte was received. A write that ends in a repeated START, or that carried no data byte, gives no pulse.
- R11: A START in the middle of a word discards the partial word and begins a new select word.
- R12: With select matching disabled (`MATCH_SEL` = 0), bits 3..1 of the select word are ignored, so any select-bit value is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line, as seen on the wire |
| sda_oe_o | output | 1 | Pull the data line low when high |
| sel_pins_i | input | SEL_W (3) | Select pin levels compared against select-word bits 3..1 |
| busy_i | input | 1 | Programming in progress; select words are not acknowledged |
| rd_data_i | input | BYTE_W (8) | Byte to send, captured when `rd_load_o` pulses |
| byte_o | output | BYTE_W (8) | Last received address or data byte |
| addr_we_o | output | 1 | One-cycle strobe: `byte_o` holds the word address |
| data_we_o | output | 1 | One-cycle strobe: `byte_o` holds a data byte |
| rd_load_o | output | 1 | One-cycle strobe: `rd_data_i` was captured for sending |
| wr_end_o | output | 1 | One-cycle strobe: a write with data ended with STOP |

## Verification
The assertions watch the following on every cycle:
- `sda_oe_o` never moves while the bus clock is high.
- The three byte strobes never coincide.
- The line is released in standby and in the hold state.
- An acknowledge of the select word never follows a busy cycle.
- `rd_load_o` and `wr_end_o` arise only from the states that may produce them.

The exact bit positions of the acknowledge and of the read data, and the values on `byte_o`, can only be shown by the bench's transfers. The same holds for select-word rejection by prefix, pin mismatch or busy, for the behaviour of a mid-word restart and of words after a STOP, and for the variant without select matching.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int PREFIX_W = 4;
    localparam logic [PREFIX_W-1:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RD_MACK,
        ST_HOLD
    } fsm_state_t;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Idle bus level is high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    localparam int LINES = 2;
    localparam int L_SCL = 0;
    localparam int L_SDA = 1;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev_q;

    assign raw[L_SCL] = scl_i;
    assign raw[L_SDA] = sda_i;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        twi_sync #(.STAGES(STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw[g]),
            .q     (cur[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= cur;
    end

    // Both lines pass the same number of stages, so their order is kept.
    assign scl_rise  =  cur[L_SCL] & ~prev_q[L_SCL];
    assign scl_fall  = ~cur[L_SCL] &  prev_q[L_SCL];
    assign start_det =  cur[L_SCL] &  prev_q[L_SCL] & prev_q[L_SDA] & ~cur[L_SDA];
    assign stop_det  =  cur[L_SCL] &  prev_q[L_SCL] & ~prev_q[L_SDA] & cur[L_SDA];
    assign sda_bit   =  cur[L_SDA];
endmodule

// File: rtl/twi_fsm.sv
module twi_fsm
    import twi_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int SEL_W     = 3,
    parameter bit MATCH_SEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_bit,
    input  logic [SEL_W-1:0]  sel_pins_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              addr_we_o,
    output logic              data_we_o,
    output logic              rd_load_o,
    output logic              wr_end_o,
    output fsm_state_t        state_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    fsm_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] byte_in;
    logic              oe_q;
    logic              phase_q;
    logic              mack_q;
    logic              rw_q;
    logic              have_data_q;
    logic [BYTE_W-1:0] byte_q;
    logic              addr_we_q, data_we_q, rd_load_q, wr_end_q;
    logic              sel_hit;
    logic              sel_ok;
    logic              word_done;

    assign byte_in   = {rx_q[BYTE_W-2:0], sda_bit};
    assign word_done = scl_rise && (cnt_q == LAST_BIT);

    if (MATCH_SEL) begin : g_match
        assign sel_hit = (byte_in[SEL_W:1] == sel_pins_i);
    end else begin : g_nomatch
        assign sel_hit = 1'b1;
    end

    assign sel_ok = (byte_in[BYTE_W-1 -: PREFIX_W] == DEV_PREFIX) && sel_hit && !busy_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_SEL;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_SEL:      if (word_done) state_d = sel_ok ? ST_SEL_ACK : ST_HOLD;
                ST_SEL_ACK:  if (scl_fall && phase_q) state_d = rw_q ? ST_RDAT : ST_ADDR;
                ST_ADDR:     if (word_done) state_d = ST_ADDR_ACK;
                ST_ADDR_ACK: if (scl_fall && phase_q) state_d = ST_WDAT;
                ST_WDAT:     if (word_done) state_d = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall && phase_q) state_d = ST_WDAT;
                ST_RDAT:     if (word_done) state_d = ST_RD_MACK;
                ST_RD_MACK:  if (scl_fall && phase_q) state_d = mack_q ? ST_RDAT : ST_HOLD;
                ST_HOLD:     state_d = ST_HOLD;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            rx_q        <= '0;
            tx_q        <= '0;
            oe_q        <= 1'b0;
            phase_q     <= 1'b0;
            mack_q      <= 1'b0;
            rw_q        <= 1'b0;
            have_data_q <= 1'b0;
            byte_q      <= '0;
            addr_we_q   <= 1'b0;
            data_we_q   <= 1'b0;
            rd_load_q   <= 1'b0;
            wr_end_q    <= 1'b0;
        end else begin
            addr_we_q <= 1'b0;
            data_we_q <= 1'b0;
            rd_load_q <= 1'b0;
            wr_end_q  <= 1'b0;
            if (start_det) begin
                cnt_q       <= '0;
                oe_q        <= 1'b0;
                phase_q     <= 1'b0;
                have_data_q <= 1'b0;
            end else if (stop_det) begin
                oe_q        <= 1'b0;
                phase_q     <= 1'b0;
                wr_end_q    <= have_data_q;
                have_data_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_SEL, ST_ADDR, ST_WDAT: begin
                        if (scl_rise) begin
                            rx_q  <= byte_in;
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == LAST_BIT) begin
                                phase_q <= 1'b0;
                                if (state_q == ST_SEL) rw_q <= sda_bit;
                                if (state_q == ST_ADDR) begin
                                    byte_q    <= byte_in;
                                    addr_we_q <= 1'b1;
                                end
                                if (state_q == ST_WDAT) begin
                                    byte_q      <= byte_in;
                                    data_we_q   <= 1'b1;
                                    have_data_q <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_SEL_ACK, ST_ADDR_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            if (!phase_q) begin
                                oe_q    <= 1'b1;
                                phase_q <= 1'b1;
                            end else begin
                                phase_q <= 1'b0;
                                cnt_q   <= '0;
                                if (state_q == ST_SEL_ACK && rw_q) begin
                                    tx_q      <= rd_data_i;
                                    oe_q      <= ~rd_data_i[BYTE_W-1];
                                    rd_load_q <= 1'b1;
                                end else begin
                                    oe_q <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == LAST_BIT) phase_q <= 1'b0;
                        end else if (scl_fall) begin
                            oe_q <= ~tx_q[BYTE_W-2];
                            tx_q <= tx_q << 1;
                        end
                    end
                    ST_RD_MACK: begin
                        if (scl_rise) begin
                            mack_q  <= ~sda_bit;
                            phase_q <= 1'b1;
                        end else if (scl_fall) begin
                            if (!phase_q) begin
                                oe_q <= 1'b0;
                            end else begin
                                phase_q <= 1'b0;
                                cnt_q   <= '0;
                                if (mack_q) begin
                                    tx_q      <= rd_data_i;
                                    oe_q      <= ~rd_data_i[BYTE_W-1];
                                    rd_load_q <= 1'b1;
                                end else begin
                                    oe_q <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_IDLE, ST_HOLD: begin
                        oe_q <= 1'b0;
                    end
                    default: oe_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe_o  = oe_q;
    assign byte_o    = byte_q;
    assign addr_we_o = addr_we_q;
    assign data_we_o = data_we_q;
    assign rd_load_o = rd_load_q;
    assign wr_end_o  = wr_end_q;
    assign state_o   = state_q;
endmodule

// File: rtl/twi_mem_front.sv
module twi_mem_front
    import twi_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter bit MATCH_SEL   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [SEL_W-1:0]  sel_pins_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              addr_we_o,
    output logic              data_we_o,
    output logic              rd_load_o,
    output logic              wr_end_o
);
    logic       scl_rise, scl_fall, start_det, stop_det, sda_bit;
    fsm_state_t fsm_state;

    twi_bus_events #(.STAGES(SYNC_STAGES)) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    twi_fsm #(
        .BYTE_W    (BYTE_W),
        .SEL_W     (SEL_W),
        .MATCH_SEL (MATCH_SEL)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_bit    (sda_bit),
        .sel_pins_i (sel_pins_i),
        .busy_i     (busy_i),
        .rd_data_i  (rd_data_i),
        .sda_oe_o   (sda_oe_o),
        .byte_o     (byte_o),
        .addr_we_o  (addr_we_o),
        .data_we_o  (data_we_o),
        .rd_load_o  (rd_load_o),
        .wr_end_o   (wr_end_o),
        .state_o    (fsm_state)
    );
endmodule

// File: rtl/twi_mem_front_chk.sv
module twi_mem_front_chk
    import twi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       busy_i,
    input logic       addr_we_o,
    input logic       data_we_o,
    input logic       rd_load_o,
    input logic       wr_end_o,
    input fsm_state_t fsm_state
);
    assert_oe_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_we_o, data_we_o, rd_load_o}));

    assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |=> !sda_oe_o || (fsm_state != ST_IDLE));

    assert_hold_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HOLD && $past(fsm_state) == ST_HOLD) |-> !sda_oe_o);

    assert_busy_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SEL_ACK && $past(fsm_state) == ST_SEL) |-> !$past(busy_i));

    assert_load_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load_o |-> ($past(fsm_state) == ST_SEL_ACK || $past(fsm_state) == ST_RD_MACK));

    assert_wr_end_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end_o |-> ($past(fsm_state) == ST_WDAT || $past(fsm_state) == ST_WDAT_ACK));
endmodule

bind twi_mem_front twi_mem_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .busy_i    (busy_i),
    .addr_we_o (addr_we_o),
    .data_we_o (data_we_o),
    .rd_load_o (rd_load_o),
    .wr_end_o  (wr_end_o),
    .fsm_state (fsm_state)
);

// File: tb/sim_twi_mem_front.sv
`timescale 1ns/1ps
module sim_twi_mem_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
    logic       oe0, oe1, sda_line;
    logic [7:0] rd_cnt = 8'd0;
    logic [7:0] rd_data;
    logic [7:0] byte0, byte1;
    logic       aw0, dw0, rl0, we0, aw1, dw1, rl1, we1;

    assign sda_line = m_sda & ~oe0 & ~oe1;
    assign rd_data  = 8'h3C ^ (rd_cnt * 8'h11);

    twi_mem_front u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(oe0),
        .sel_pins_i(3'b010), .busy_i(busy), .rd_data_i(rd_data), .byte_o(byte0),
        .addr_we_o(aw0), .data_we_o(dw0), .rd_load_o(rl0), .wr_end_o(we0));

    twi_mem_front #(.MATCH_SEL(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(oe1),
        .sel_pins_i(3'b101), .busy_i(busy), .rd_data_i(rd_data), .byte_o(byte1),
        .addr_we_o(aw1), .data_we_o(dw1), .rd_load_o(rl1), .wr_end_o(we1));

    int    n_chk = 0, n_fail = 0;
    int    wr_end_n = 0, pulse_n = 0;
    bit    chk_on = 1'b1, exp_oe = 1'b0, done = 1'b0;
    string cur_req = "R1";
    logic [7:0] q_addr[$];
    logic [7:0] q_data[$];

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Reference comparison of the open-drain enable on every clock.
    always @(negedge clk) begin
        if (chk_on) check(oe0 === exp_oe, cur_req, int'(oe0), int'(exp_oe));
        if (rst_n) begin
            if (aw0) q_addr.push_back(byte0);
            if (dw0) q_data.push_back(byte0);
            if (we0) wr_end_n++;
            if (rl0) rd_cnt <= rd_cnt + 8'd1;
            if (aw0 | dw0 | rl0 | we0) pulse_n++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        chk_on = 0; exp_oe = 0;
        m_sda = 1; tick(6); m_scl = 1; tick(12); m_sda = 0; tick(12); m_scl = 0;
    endtask

    task automatic bus_stop();
        chk_on = 0; exp_oe = 0;
        tick(6); m_sda = 0; tick(6); m_scl = 1; tick(12); m_sda = 1; tick(12);
    endtask

    // exp1: -1 means the second instance is not checked.
    task automatic send_bits(logic [7:0] b, int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            tick(6); m_sda = b[i]; exp_oe = 0; chk_on = 1;
            tick(6); m_scl = 1; tick(12); m_scl = 0; chk_on = 0;
        end
    endtask

    task automatic send_byte(logic [7:0] b, bit ack0, int exp1, string req);
        cur_req = req;
        send_bits(b, 8);
        tick(6); m_sda = 1; exp_oe = ack0; chk_on = 1;
        tick(6); m_scl = 1; tick(6);
        if (exp1 >= 0) check(oe1 === exp1[0], "R12", int'(oe1), exp1);
        tick(6); m_scl = 0; chk_on = 0;
    endtask

    task automatic recv_byte(logic [7:0] expb, bit mack);
        cur_req = "R8";
        for (int i = 7; i >= 0; i--) begin
            tick(6); m_sda = 1; exp_oe = ~expb[i]; chk_on = 1;
            tick(6); m_scl = 1; tick(12); m_scl = 0; chk_on = 0;
        end
        cur_req = "R9";
        tick(6); m_sda = ~mack; exp_oe = 0; chk_on = 1;
        tick(6); m_scl = 1; tick(12); m_scl = 0; chk_on = 0;
    endtask

    function automatic logic [7:0] rd_model(int k);
        return 8'h3C ^ 8'(k * 8'h11);
    endfunction

    initial begin
        int p0;
        tick(5);
        rst_n = 1;
        tick(4);
        // R1: reset state
        check(oe0 === 1'b0 && pulse_n == 0, "R1", int'(oe0), 0);

        // R7 / R10: write with address and three data bytes, then STOP
        bus_start();
        send_byte(8'hA4, 1, 1, "R7");
        send_byte(8'h35, 1, 1, "R7");
        send_byte(8'h11, 1, 1, "R7");
        send_byte(8'h22, 1, 1, "R7");
        send_byte(8'h33, 1, 1, "R7");
        bus_stop();
        tick(4);
        check(q_addr.size() == 1 && q_addr[0] == 8'h35, "R7", q_addr.size() > 0 ? int'(q_addr[0]) : -1, 8'h35);
        check(q_data.size() == 3, "R7", q_data.size(), 3);
        if (q_data.size() == 3)
            check(q_data[0] == 8'h11 && q_data[1] == 8'h22 && q_data[2] == 8'h33, "R7",
                  int'({q_data[0], q_data[1], q_data[2]}), 24'h112233);
        check(wr_end_n == 1, "R10", wr_end_n, 1);
        q_addr.delete(); q_data.delete();

        // R8 / R9: address set by a write, repeated START, three-byte read
        m_scl = 0;
        bus_start();
        send_byte(8'hA4, 1, 1, "R7");
        send_byte(8'h40, 1, 1, "R7");
        bus_start();
        send_byte(8'hA5, 1, 1, "R3");
        recv_byte(rd_model(0), 1);
        recv_byte(rd_model(1), 1);
        recv_byte(rd_model(2), 0);
        tick(2);
        check(oe0 === 1'b0, "R9", int'(oe0), 0);
        bus_stop();
        tick(4);
        check(rd_cnt == 8'd3, "R9", rd_cnt, 3);
        check(q_addr.size() == 1 && q_addr[0] == 8'h40, "R7", q_addr.size(), 1);
        check(wr_end_n == 1, "R10", wr_end_n, 1);
        q_addr.delete();

        // R3: wrong prefix, rest of transfer ignored
        m_scl = 0;
        p0 = pulse_n;
        bus_start();
        send_byte(8'hB4, 0, 0, "R3");
        send_byte(8'h55, 0, -1, "R3");
        bus_stop();
        tick(4);
        check(pulse_n == p0, "R3", pulse_n - p0, 0);

        // R4 / R12: select bits 101 do not match u0, the variant accepts them
        m_scl = 0;
        bus_start();
        send_byte(8'hAA, 0, 1, "R4");
        send_byte(8'h12, 0, 1, "R4");
        bus_stop();
        tick(4);
        check(q_addr.size() == 0 && pulse_n == p0, "R4", q_addr.size(), 0);

        // R6: busy blocks the acknowledge, idle again gives it back
        m_scl = 0;
        busy = 1;
        bus_start();
        send_byte(8'hA4, 0, 0, "R6");
        bus_stop();
        busy = 0;
        m_scl = 0;
        bus_start();
        send_byte(8'hA4, 1, 1, "R6");
        bus_stop();
        tick(4);
        check(wr_end_n == 1, "R10", wr_end_n, 1);

        // R11: START after three bits restarts the select word
        m_scl = 0;
        bus_start();
        cur_req = "R11";
        send_bits(8'hFF, 3);
        bus_start();
        send_byte(8'hA4, 1, 1, "R11");
        send_byte(8'h07, 1, 1, "R11");
        bus_stop();
        tick(4);
        check(q_addr.size() == 1 && q_addr[0] == 8'h07, "R11", q_addr.size() > 0 ? int'(q_addr[0]) : -1, 7);
        check(wr_end_n == 1, "R10", wr_end_n, 1);

        // R2: after STOP, a word without START is not acknowledged
        m_scl = 0;
        p0 = pulse_n;
        send_byte(8'hA4, 0, 0, "R2");
        bus_stop();
        tick(4);
        check(pulse_n == p0, "R2", pulse_n - p0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule